// File: doc/BRIEF.md
# Shared Timer Prescaler with Per-Channel Clock Select

This block generates count-enable pulses for two timer channels from a single free-running clock divider. Each channel has its own 3-bit select that chooses one of several sources: off, every system clock, one of four divided taps, or rising or falling edges on that channel's external clock pin. Each output is a one-cycle enable that a downstream counter adds to its count.

The divider runs on every system clock whatever the selects are. Its only reset is a synchronous clear input, which software pulses to align timer activity with program flow. The clear moves the tap phase of both channels, so a channel that is not being resynchronized is also affected when it uses a divided source. The external pins are sampled through a two-stage synchronizer and then compared with a delayed copy to find edges.

Top module: `tmr_prescale_sel`

## Requirements
- R1: Asynchronous active-low reset sets the divider to zero, so in the first cycle after reset every divided tap is active.
- R2: Select code 0 stops the channel. Its enable stays low.
- R3: Select code 1 drives the enable high in every system clock cycle.
- R4: Select codes 2, 3, 4 and 5 give one single-cycle pulse for every 8, 64, 256 and 1024 system clocks. The pulse appears in the cycle in which the low 3, 6, 8 or 10 bits of the divider are zero.
- R5: The two channels use their selects independently. Each channel's pulse rate depends only on its own code.
- R6: Changing a select does not reset or hold the divider. The first pulse after a channel switches to a divided source comes when the divider next wraps, within N cycles for divisor N.
- R7: When the clear input is high at a clock edge, the divider is zero in the cycle that follows. Both channels' divided taps pulse in that cycle, and the next tap-8 pulse comes 8 cycles later.
- R8: Select code 7 gives one pulse per rising edge of the channel's external pin. The pulse is high in the second cycle after the first clock edge that samples the new pin level.
- R9: Select code 6 gives one pulse per falling edge of the pin, with the same latency. Rising edges give no pulse in this mode.
- R10: A pin that holds each level for at least two system clocks has every one of its edges counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| presc_clr | input | 1 | Synchronous clear of the shared divider |
| sel_a | input | 3 | Source select for channel A |
| sel_b | input | 3 | Source select for channel B |
| ext_a | input | 1 | External clock pin for channel A |
| ext_b | input | 1 | External clock pin for channel B |
| tick_a | output | 1 | Count enable for channel A |
| tick_b | output | 1 | Count enable for channel B |

## Verification
A divider clear and the tap pulses of both channels fall in the same cycle. The bench sets channel A to divide by 64 and channel B to divide by 256, pulses the clear at an arbitrary phase, and checks that both enables are high together in the following cycle and that channel A's next pulse comes exactly 64 cycles later. An external edge pulse on one channel can also land in the same cycle as a tap pulse on the other. Here each channel's pulse count is compared with a count that the bench derives from its own pin stimulus and from the tap period.

// File: rtl/tmr_prescale_sel.sv
module tmr_prescale_sel #(
  parameter int DIV_W  = 10,
  parameter int TAP0_W = 3,
  parameter int TAP1_W = 6,
  parameter int TAP2_W = 8,
  parameter int SYNC_N = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       presc_clr,
  input  logic [2:0] sel_a,
  input  logic [2:0] sel_b,
  input  logic       ext_a,
  input  logic       ext_b,
  output logic       tick_a,
  output logic       tick_b
);
  localparam int NCH = 2;

  logic [DIV_W-1:0] div_q;
  logic [3:0]       tap;
  logic [NCH-1:0][2:0] sel_v;
  logic [NCH-1:0]   ext_v;
  logic [NCH-1:0]   tick_v;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         div_q <= '0;
    else if (presc_clr) div_q <= '0;
    else                div_q <= div_q + 1'b1;

  assign tap[0] = (div_q[TAP0_W-1:0] == '0);
  assign tap[1] = (div_q[TAP1_W-1:0] == '0);
  assign tap[2] = (div_q[TAP2_W-1:0] == '0);
  assign tap[3] = (div_q == '0);

  assign sel_v  = {sel_b, sel_a};
  assign ext_v  = {ext_b, ext_a};
  assign tick_a = tick_v[0];
  assign tick_b = tick_v[1];

  assert_clr_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
    presc_clr |=> (div_q == '0));
  assert_free_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !presc_clr |=> (div_q == DIV_W'($past(div_q) + 1'b1)));

  for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
    logic [SYNC_N:0] sh;
    logic            rise, fall, t;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n) sh <= '0;
      else        sh <= {sh[SYNC_N-1:0], ext_v[ch]};

    assign rise = sh[SYNC_N-1] & ~sh[SYNC_N];
    assign fall = ~sh[SYNC_N-1] & sh[SYNC_N];

    always_comb
      case (sel_v[ch])
        3'd0:    t = 1'b0;
        3'd1:    t = 1'b1;
        3'd2:    t = tap[0];
        3'd3:    t = tap[1];
        3'd4:    t = tap[2];
        3'd5:    t = tap[3];
        3'd6:    t = fall;
        default: t = rise;
      endcase

    assign tick_v[ch] = t;

    assert_stop_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v[ch] == 3'd0) |-> !tick_v[ch]);
    assert_every_clk_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v[ch] == 3'd1) |-> tick_v[ch]);
    assert_tap_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v[ch] == 3'd2 && tick_v[ch] && !presc_clr)
        |=> (sel_v[ch] != 3'd2 || !tick_v[ch]));
    assert_rise_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v[ch] == 3'd7 && tick_v[ch]) |=> !(sel_v[ch] == 3'd7 && tick_v[ch]));
    assert_fall_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_v[ch] == 3'd6 && tick_v[ch]) |=> !(sel_v[ch] == 3'd6 && tick_v[ch]));
  end
endmodule

// File: tb/sim_tmr_prescale_sel.sv
module sim_tmr_prescale_sel;
  logic clk = 0, rst_n = 0, presc_clr = 0;
  logic [2:0] sel_a = 0, sel_b = 0;
  logic ext_a = 0, ext_b = 0;
  logic tick_a, tick_b;
  int checks = 0, fails = 0;
  bit done = 0;

  always #2 clk = ~clk;

  tmr_prescale_sel u0 (.clk(clk), .rst_n(rst_n), .presc_clr(presc_clr),
    .sel_a(sel_a), .sel_b(sel_b), .ext_a(ext_a), .ext_b(ext_b),
    .tick_a(tick_a), .tick_b(tick_b));

  localparam int WIN = 2048;
  // sel_a, sel_b, expected A count, expected B count over WIN cycles after a clear
  localparam int VEC [6][4] = '{
    '{0, 1, 0,    2048},
    '{1, 2, 2048, 256},
    '{2, 3, 256,  32},
    '{3, 4, 32,   8},
    '{4, 5, 8,    2},
    '{5, 0, 2,    0}};

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 4);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    summary();
  end

  initial begin
    int na, nb, n;
    // R1: reset state
    sel_a = 3'd2; sel_b = 3'd5;
    repeat (3) @(negedge clk);
    rst_n = 1;
    chk("R1 tap8 after reset", tick_a, 1);
    chk("R1 tap1024 after reset", tick_b, 1);
    @(negedge clk);
    chk("R1 tap8 one cycle later", tick_a, 0);

    // R2..R5: vector table
    for (int v = 0; v < 6; v++) begin
      sel_a = 3'(VEC[v][0]); sel_b = 3'(VEC[v][1]); presc_clr = 1;
      @(negedge clk);
      presc_clr = 0;
      na = 0; nb = 0;
      for (int i = 0; i < WIN; i++) begin
        na += int'(tick_a); nb += int'(tick_b);
        @(negedge clk);
      end
      chk($sformatf("R2/R3/R4/R5 vec%0d chA", v), na, VEC[v][2]);
      chk($sformatf("R2/R3/R4/R5 vec%0d chB", v), nb, VEC[v][3]);
    end

    // R7: clear shifts both channels together
    sel_a = 3'd3; sel_b = 3'd4;
    repeat (37) @(negedge clk);
    presc_clr = 1;
    @(negedge clk);
    presc_clr = 0;
    chk("R7 chA tap after clear", tick_a, 1);
    chk("R7 chB tap after clear", tick_b, 1);
    n = 0;
    do begin @(negedge clk); n++; end while (!tick_a);
    chk("R7 chA next tap64 distance", n, 64);

    // R6: switching select does not touch the divider
    sel_a = 3'd2; sel_b = 3'd0; presc_clr = 1;
    @(negedge clk);
    presc_clr = 0;
    repeat (3) @(negedge clk);
    sel_b = 3'd5;
    n = 0;
    while (!tick_b) begin @(negedge clk); n++; end
    chk("R6 first tap1024 after switch", n, 1021);
    chk("R6 chA tap8 aligned at wrap", tick_a, 1);

    // R8: rising edge latency
    sel_a = 3'd7; sel_b = 3'd0; ext_a = 0;
    repeat (4) @(negedge clk);
    ext_a = 1;
    chk("R8 no pulse at drive", tick_a, 0);
    @(negedge clk);
    chk("R8 no pulse one cycle", tick_a, 0);
    @(negedge clk);
    chk("R8 pulse two cycles", tick_a, 1);
    @(negedge clk);
    chk("R8 pulse ends", tick_a, 0);

    // R9: falling edge, and rising ignored
    sel_a = 3'd6;
    repeat (3) @(negedge clk);
    ext_a = 0;
    @(negedge clk);
    @(negedge clk);
    chk("R9 falling pulse", tick_a, 1);
    repeat (3) @(negedge clk);
    ext_a = 1; n = 0;
    for (int i = 0; i < 8; i++) begin n += int'(tick_a); @(negedge clk); end
    chk("R9 rising ignored", n, 0);

    // R10: minimum-width toggling, with tap ticks on the other channel
    sel_a = 3'd2; sel_b = 3'd7; ext_b = 0; presc_clr = 1;
    @(negedge clk);
    presc_clr = 0;
    na = 0; nb = 0;
    for (int i = 0; i < 80; i++) begin
      ext_b = ((i / 2) % 2) == 1;
      na += int'(tick_a); nb += int'(tick_b);
      @(negedge clk);
    end
    ext_b = 0;
    for (int i = 0; i < 8; i++) begin
      na += int'(tick_a); nb += int'(tick_b);
      @(negedge clk);
    end
    chk("R10 every rising edge counted", nb, 20);
    chk("R5 chA tap8 alongside ext", na, 11);

    summary();
  end
endmodule